// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Flags

This block sits beside a two-port shared memory and gives each port a doorbell. The top two locations of the address space serve as mailboxes. The lower one, `2^ADDR_W - 2` (0x3FE by default), belongs to the left port. The upper one, `2^ADDR_W - 1` (0x3FF by default), belongs to the right port. When one port writes into the other port's mailbox, the owner's interrupt is raised. The owner drops its interrupt by reading its own mailbox. The mailbox byte itself is ordinary data and is held in the shared array. This block only watches the access strobes of both ports.

Each port presents these signals to the block:
- an active-high select,
- an active-high read enable,
- an active-high write enable,
- its address,
- an active-high busy indication from the arbiter.

A port that is flagged busy has lost contention for its access. Such a port can neither raise nor clear a flag. Both flags are registered, so they change on the clock edge that follows the qualifying access. If `MBOX_EN` is 0, the block drives both interrupts inactive. The two top locations then behave as plain storage.

Top module: `mbx_irq`

## Requirements
- R1: After a synchronous reset, `l_irq_n` and `r_irq_n` are both 1 (inactive) on the clock edge at which `rst` is high. This holds even if a flag was active before the reset.
- R2: A right-port write lowers `l_irq_n` one clock later. A write means `r_sel`=1 and `r_wr`=1 with `r_busy`=0. The address must be the left mailbox, 0x3FE.
- R3: A left-port read raises `l_irq_n` again one clock later. A read means `l_sel`=1 and `l_rd`=1 with `l_busy`=0, at address 0x3FE. The level of `l_wr` does not matter for this clear.
- R4: A left-port write lowers `r_irq_n` one clock later. A write means `l_sel`=1 and `l_wr`=1 with `l_busy`=0. The address must be the right mailbox, 0x3FF.
- R5: A right-port read raises `r_irq_n` again one clock later. A read means `r_sel`=1 and `r_rd`=1 with `r_busy`=0, at address 0x3FF.
- R6: When the acting port's busy input is 1, the set or clear that its access would cause does not take place. The flag keeps its value.
- R7: When the same flag is set and cleared in the same cycle, the set wins and the interrupt ends up active.
- R8: None of the following changes either flag:
  - an access with select 0;
  - an access to any non-mailbox address;
  - a port writing its own mailbox without read enable;
  - a port reading the other port's mailbox;
  - a port selecting its mailbox with neither read nor write enable.
- R9: With `MBOX_EN`=0, both interrupt outputs stay at 1 for any traffic.
- R10: A flag holds its value on every cycle that has no qualifying set or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select |
| l_rd | input | 1 | Left port read (output) enable |
| l_wr | input | 1 | Left port write enable |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port lost arbitration |
| r_sel | input | 1 | Right port select |
| r_rd | input | 1 | Right port read (output) enable |
| r_wr | input | 1 | Right port write enable |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port lost arbitration |
| l_irq_n | output | 1 | Left port interrupt, active low, registered |
| r_irq_n | output | 1 | Right port interrupt, active low, registered |

## Verification
The doorbell path is driven with several kinds of access:
- clean cross-port writes and owner reads, which separate the set path from the clear path on each side;
- near misses: wrong address, own-box writes, reads of the peer box, dropped select, and a missing read enable, which show that the address and strobe decode is exact;
- busy-vetoed sets and clears, which show that a losing port leaves the flag alone;
- simultaneous set and clear of one flag, which exposes the priority order.

A second instance with the feature disabled sees the same traffic, which tells the two build variants apart. A reset while both flags are active confirms that the flags return to idle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Access strobes of one port, all active high.
  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
    logic busy;
  } port_ctl_t;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Mailbox of a side: the left box sits one below the top, the right box at the top.
  function automatic int unsigned box_addr(int unsigned aw, side_e s);
    return (32'd1 << aw) - 32'd2 + int'(s);
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OWN_BOX  = 1022,
  parameter int unsigned PEER_BOX = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              post,
  output logic              ack
);

  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

  logic granted;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    granted  = ctl.sel & ~ctl.busy;
    hit_own  = (addr == OWN_A);
    hit_peer = (addr == PEER_A);
    post     = granted & ctl.wr & hit_peer;
    ack      = granted & ctl.rd & hit_own;
  end

  // R6
  busy_veto_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.busy |-> (!post && !ack));

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.sel |-> (!post && !ack));

  // R8
  addr_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != OWN_A && addr != PEER_A) |-> (!post && !ack));

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (rst)      irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> irq_n);

  // R7
  set_first_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> !irq_n);

  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> irq_n);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter bit          MBOX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_rd,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_sel,
  input  logic              r_rd,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam int unsigned NSIDE = 2;
  localparam int unsigned BOX_L = box_addr(ADDR_W, SIDE_L);
  localparam int unsigned BOX_R = box_addr(ADDR_W, SIDE_R);

  port_ctl_t         ctl  [NSIDE];
  logic [ADDR_W-1:0] addr [NSIDE];
  logic [NSIDE-1:0]  post;
  logic [NSIDE-1:0]  ack;
  logic [NSIDE-1:0]  irq_n;

  always_comb begin
    ctl[SIDE_L]  = '{sel: l_sel, rd: l_rd, wr: l_wr, busy: l_busy};
    ctl[SIDE_R]  = '{sel: r_sel, rd: r_rd, wr: r_wr, busy: r_busy};
    addr[SIDE_L] = l_addr;
    addr[SIDE_R] = r_addr;
  end

  generate
    if (MBOX_EN) begin : g_on
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int unsigned OWN  = (s == 0) ? BOX_L : BOX_R;
        localparam int unsigned PEER = (s == 0) ? BOX_R : BOX_L;

        mbx_port_dec #(
          .ADDR_W  (ADDR_W),
          .OWN_BOX (OWN),
          .PEER_BOX(PEER)
        ) dec_i (
          .clk (clk),
          .rst (rst),
          .ctl (ctl[s]),
          .addr(addr[s]),
          .post(post[s]),
          .ack (ack[s])
        );

        // A side's flag is set by the opposite side posting, cleared by its own ack.
        mbx_flag flag_i (
          .clk  (clk),
          .rst  (rst),
          .set  (post[NSIDE-1-s]),
          .clr  (ack[s]),
          .irq_n(irq_n[s])
        );
      end
    end else begin : g_off
      always_comb begin
        post  = '0;
        ack   = '0;
        irq_n = '1;
      end
    end
  endgenerate

  assign l_irq_n = irq_n[SIDE_L];
  assign r_irq_n = irq_n[SIDE_R];

  // R2
  left_raise_chk: assert property (@(posedge clk) disable iff (rst || !MBOX_EN)
    (r_sel && r_wr && !r_busy && r_addr == ADDR_W'(BOX_L)) |=> !l_irq_n);

  // R4
  right_raise_chk: assert property (@(posedge clk) disable iff (rst || !MBOX_EN)
    (l_sel && l_wr && !l_busy && l_addr == ADDR_W'(BOX_R)) |=> !r_irq_n);

  // R5
  right_clear_chk: assert property (@(posedge clk) disable iff (rst || !MBOX_EN)
    (r_sel && r_rd && !r_busy && r_addr == ADDR_W'(BOX_R) &&
     !(l_sel && l_wr && !l_busy && l_addr == ADDR_W'(BOX_R))) |=> r_irq_n);

endmodule

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb_top;

  localparam int AW = 10;
  localparam int VW = 4 + AW + 4 + AW + 2 + 8;
  localparam int NV = 18;

  // Entry: {l ctl(sel,rd,wr,busy), l addr, r ctl, r addr, exp l_irq_n, exp r_irq_n, req}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0000, 10'h000, 4'b0000, 10'h000, 2'b11, 8'd1},  // R1 idle after reset
    {4'b0000, 10'h000, 4'b1010, 10'h3FE, 2'b01, 8'd2},  // R2 right posts left box
    {4'b0000, 10'h000, 4'b0000, 10'h000, 2'b01, 8'd10}, // R10 flag held
    {4'b1100, 10'h3FF, 4'b0000, 10'h000, 2'b01, 8'd8},  // R8 left reads peer box
    {4'b1101, 10'h3FE, 4'b0000, 10'h000, 2'b01, 8'd6},  // R6 busy blocks clear
    {4'b1110, 10'h3FE, 4'b0000, 10'h000, 2'b11, 8'd3},  // R3 clear with wr high
    {4'b1010, 10'h3FF, 4'b0000, 10'h000, 2'b10, 8'd4},  // R4 left posts right box
    {4'b0000, 10'h000, 4'b1010, 10'h3FF, 2'b10, 8'd8},  // R8 right writes own box
    {4'b0000, 10'h000, 4'b0100, 10'h3FF, 2'b10, 8'd8},  // R8 no select
    {4'b0000, 10'h000, 4'b1101, 10'h3FF, 2'b10, 8'd6},  // R6 busy blocks clear
    {4'b0000, 10'h000, 4'b1100, 10'h3FF, 2'b11, 8'd5},  // R5 right clears
    {4'b0000, 10'h000, 4'b1011, 10'h3FE, 2'b11, 8'd6},  // R6 busy blocks set
    {4'b1010, 10'h3FF, 4'b1100, 10'h3FF, 2'b10, 8'd7},  // R7 set beats clear (right)
    {4'b1100, 10'h3FE, 4'b1010, 10'h3FE, 2'b00, 8'd7},  // R7 set beats clear (left)
    {4'b0000, 10'h000, 4'b1010, 10'h3FD, 2'b00, 8'd8},  // R8 plain address
    {4'b1000, 10'h3FE, 4'b0000, 10'h000, 2'b00, 8'd8},  // R8 select without read
    {4'b1100, 10'h3FE, 4'b0000, 10'h000, 2'b10, 8'd3},  // R3 left clears
    {4'b0000, 10'h000, 4'b1100, 10'h3FF, 2'b11, 8'd5}   // R5 right clears
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_rd = 0, l_wr = 0, l_busy = 0;
  logic r_sel = 0, r_rd = 0, r_wr = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n, off_l_n, off_r_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mbx_irq #(.ADDR_W(AW), .MBOX_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  mbx_irq #(.ADDR_W(AW), .MBOX_EN(1'b0)) dut_off_i (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_rd(r_rd), .r_wr(r_wr), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(off_l_n), .r_irq_n(off_r_n)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_n {l,r} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] lc, input logic [AW-1:0] la,
                       input logic [3:0] rc, input logic [AW-1:0] ra);
    @(negedge clk);
    {l_sel, l_rd, l_wr, l_busy} = lc;
    l_addr = la;
    {r_sel, r_rd, r_wr, r_busy} = rc;
    r_addr = ra;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {l_irq_n, r_irq_n}, 2'b11);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1 -: 4], v[VW-5 -: AW], v[VW-5-AW -: 4], v[VW-9-AW -: AW]);
      check($sformatf("R%0d vec%0d", v[7:0], i), {l_irq_n, r_irq_n}, v[9:8]);
      check("R9", {off_l_n, off_r_n}, 2'b11);
    end

    // R2 and R4 together, then R1 reset while both flags are active.
    drive(4'b1010, 10'h3FF, 4'b1010, 10'h3FE);
    check("R2/R4 both", {l_irq_n, r_irq_n}, 2'b00);
    check("R9", {off_l_n, off_r_n}, 2'b11);
    drive(4'b0000, 10'h000, 4'b0000, 10'h000);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset", {l_irq_n, r_irq_n}, 2'b11);
    @(negedge clk);
    rst = 1'b0;
    // R10: idle after reset keeps both flags inactive.
    drive(4'b0000, 10'h000, 4'b0000, 10'h000);
    check("R10 idle", {l_irq_n, r_irq_n}, 2'b11);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule